// File: doc/BRIEF.md
# Key-Protected Extended Display Register File

This block is a small indexed register file for a display controller. It is reached through a host port with two addresses. One address holds the index and the other reads or writes the register that the index selects. Most of the extended registers stay hidden until software writes two separate key values. The first key opens one group of registers. A single register needs both keys open before it can be reached.

Three values that the rest of the display pipeline uses are built from fields held in different indices:
- a 6-bit memory bank number,
- the three high bits of the display start address,
- a 10-bit linear aperture base, given in 4 MB units.

Index 30h is a read-only identification byte, and a parameter sets its value. Software can detect the block by checking whether the bank register accepts writes before and after the first key is written.

The host port takes one access per cycle and never stalls, so there is no back-pressure. A write takes effect at the clock edge. Read data is combinational from the current select and index.

Top module: `xcrtc_regfile`

## Requirements
- R1: A write with `host_sel`=0 loads the index register. A read with `host_sel`=0 returns the current index.
- R2: Key 1 lives at index 38h. Writing 48h opens group 1, and writing any other value closes it. Index 38h always reads back the last value written to it.
- R3: Key 2 lives at index 39h. Writing A5h opens it and writing 5Ah closes it. Any other value leaves its state unchanged. Index 39h always reads back the last value written to it.
- R4: Group 1 is indices 31h, 35h, 59h and 5Ah. These registers can be written and read back only while key 1 is open. While key 1 is closed, writes to them are ignored and reads return 00h.
- R5: Index 51h can be written and read only while both keys are open. Otherwise writes to it are ignored and reads return 00h.
- R6: `bank_num` is made of index 51h bits 3:2 (as bits 5:4) and index 35h bits 3:0 (as bits 3:0).
- R7: `disp_start_hi` is index 51h bit 0 (as bit 2) and index 31h bits 5:4 (as bits 1:0). These are display start address bits 18..16.
- R8: `aper_base` is index 59h bits 1:0 (as bits 9:8) and index 5Ah (as bits 7:0).
- R9: Index 30h reads `CHIP_ID` whatever the key state. Writes to index 30h have no effect.
- R10: After reset, both keys are closed, and the index and all stored registers are zero. Indices outside the ones listed here read 00h and ignore writes.
- R11: Closing a key does not clear stored values. The assembled outputs keep them, and they change only on an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wr | input | 1 | Write strobe for the selected port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected port (combinational) |
| bank_num | output | 6 | Assembled memory bank number |
| disp_start_hi | output | 3 | Display start address bits 18..16 |
| aper_base | output | 10 | Linear aperture base in 4 MB units |

## Verification
The assertions check every cycle that each key responds to its own values. They also check that a write to a locked register leaves it unchanged, that locked and unknown indices read zero, that the identification byte is always returned, and that the assembled outputs move only on a write. Other behaviour can only be shown by the bench's scenarios:
- the full detection sequence, with the bank register refusing and then accepting data;
- index 51h staying closed with only one key open;
- values surviving a relock;
- the exact bit placement inside each assembled output.

A behavioural model runs alongside the design through a long mixed stream of writes.

// File: rtl/xcrtc_pkg.sv
package xcrtc_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] IDX_ID   = 8'h30;
  localparam logic [DW-1:0] IDX_KEY1 = 8'h38;
  localparam logic [DW-1:0] IDX_KEY2 = 8'h39;
  localparam logic [DW-1:0] KEY1_OPEN = 8'h48;
  localparam logic [DW-1:0] KEY2_OPEN = 8'hA5;
  localparam logic [DW-1:0] KEY2_SHUT = 8'h5A;

  localparam int BANK_W  = 6;
  localparam int START_W = 3;
  localparam int APER_W  = 10;

  typedef enum int {SL_START = 0, SL_BANK = 1, SL_HIGH = 2, SL_APHI = 3, SL_APLO = 4} slot_e;
  localparam int NSLOT = 5;

  function automatic logic [DW-1:0] slot_index(int s);
    case (s)
      SL_START: return 8'h31;
      SL_BANK:  return 8'h35;
      SL_HIGH:  return 8'h51;
      SL_APHI:  return 8'h59;
      default:  return 8'h5A;
    endcase
  endfunction

  function automatic logic slot_dual(int s);
    return s == SL_HIGH;
  endfunction
endpackage

// File: rtl/xcrtc_lock.sv
module xcrtc_lock
  import xcrtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] key1_val,
  output logic [DW-1:0] key2_val,
  output logic          key1_open,
  output logic          key2_open
);
  logic hit1, hit2;
  assign hit1 = wr_en && (addr == IDX_KEY1);
  assign hit2 = wr_en && (addr == IDX_KEY2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key1_val  <= '0;
      key2_val  <= '0;
      key2_open <= 1'b0;
    end else begin
      if (hit1) key1_val <= wdata;
      if (hit2) begin
        key2_val <= wdata;
        if (wdata == KEY2_OPEN)      key2_open <= 1'b1;
        else if (wdata == KEY2_SHUT) key2_open <= 1'b0;
      end
    end
  end

  assign key1_open = (key1_val == KEY1_OPEN);

  a_r2_key1_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && wdata == KEY1_OPEN) |=> key1_open);
  a_r2_key1_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && wdata != KEY1_OPEN) |=> !key1_open);
  a_r3_key2_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (hit2 && wdata == KEY2_OPEN) |=> key2_open);
  a_r3_key2_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    (hit2 && wdata == KEY2_SHUT) |=> !key2_open);
  a_r3_key2_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hit2 && (wdata == KEY2_OPEN || wdata == KEY2_SHUT))) |=> $stable(key2_open));
endmodule

// File: rtl/xcrtc_slots.sv
module xcrtc_slots
  import xcrtc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  input  logic                       key1_open,
  input  logic                       key2_open,
  output logic [NSLOT-1:0][DW-1:0]   slot_q,
  output logic [NSLOT-1:0]           slot_hit,
  output logic [NSLOT-1:0]           slot_ok
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [DW-1:0] MY_IDX = slot_index(s);
    localparam bit            DUAL   = slot_dual(s);

    assign slot_hit[s] = (addr == MY_IDX);
    if (DUAL) begin : g_dual
      assign slot_ok[s] = key1_open && key2_open;
    end else begin : g_single
      assign slot_ok[s] = key1_open;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                slot_q[s] <= '0;
      else if (wr_en && slot_hit[s] && slot_ok[s]) slot_q[s] <= wdata;
    end

    a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && slot_hit[s] && !key1_open) |=> $stable(slot_q[s]));
    if (DUAL) begin : g_chk_dual
      a_r5_needs_both_keys: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slot_hit[s] && !key2_open) |=> $stable(slot_q[s]));
    end
  end

  a_r10_one_slot_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));
endmodule

// File: rtl/xcrtc_assemble.sv
module xcrtc_assemble
  import xcrtc_pkg::*;
(
  input  logic [NSLOT-1:0][DW-1:0] slot_q,
  output logic [BANK_W-1:0]        bank_num,
  output logic [START_W-1:0]       disp_start_hi,
  output logic [APER_W-1:0]        aper_base
);
  logic [DW-1:0] r_start, r_bank, r_high, r_aphi, r_aplo;
  assign r_start = slot_q[SL_START];
  assign r_bank  = slot_q[SL_BANK];
  assign r_high  = slot_q[SL_HIGH];
  assign r_aphi  = slot_q[SL_APHI];
  assign r_aplo  = slot_q[SL_APLO];

  assign bank_num      = {r_high[3:2], r_bank[3:0]};
  assign disp_start_hi = {r_high[0], r_start[5:4]};
  assign aper_base     = {r_aphi[1:0], r_aplo};

  logic unused_bits;
  assign unused_bits = ^{r_start[7:6], r_start[3:0], r_bank[7:4],
                         r_high[7:4], r_high[1], r_aphi[7:2]};
endmodule

// File: rtl/xcrtc_regfile.sv
module xcrtc_regfile
  import xcrtc_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h90
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_sel,
  input  logic                host_wr,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  output logic [BANK_W-1:0]   bank_num,
  output logic [START_W-1:0]  disp_start_hi,
  output logic [APER_W-1:0]   aper_base
);
  logic [DW-1:0]             idx_q;
  logic                      data_wr;
  logic [DW-1:0]             key1_val, key2_val;
  logic                      key1_open, key2_open;
  logic [NSLOT-1:0][DW-1:0]  slot_q;
  logic [NSLOT-1:0]          slot_hit, slot_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                    idx_q <= '0;
    else if (host_wr && !host_sel) idx_q <= host_wdata;
  end

  assign data_wr = host_wr && host_sel;

  xcrtc_lock u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .addr(idx_q), .wdata(host_wdata),
    .key1_val(key1_val), .key2_val(key2_val),
    .key1_open(key1_open), .key2_open(key2_open)
  );

  xcrtc_slots u_slots (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .addr(idx_q), .wdata(host_wdata),
    .key1_open(key1_open), .key2_open(key2_open),
    .slot_q(slot_q), .slot_hit(slot_hit), .slot_ok(slot_ok)
  );

  xcrtc_assemble u_asm (
    .slot_q(slot_q), .bank_num(bank_num),
    .disp_start_hi(disp_start_hi), .aper_base(aper_base)
  );

  logic [DW-1:0] slot_rd;
  always_comb begin
    slot_rd = '0;
    for (int s = 0; s < NSLOT; s++)
      if (slot_hit[s] && slot_ok[s]) slot_rd = slot_q[s];
  end

  always_comb begin
    if (!host_sel)               host_rdata = idx_q;
    else if (idx_q == IDX_ID)    host_rdata = CHIP_ID;
    else if (idx_q == IDX_KEY1)  host_rdata = key1_val;
    else if (idx_q == IDX_KEY2)  host_rdata = key2_val;
    else                         host_rdata = slot_rd;
  end

  a_r9_id_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && idx_q == IDX_ID) |-> host_rdata == CHIP_ID);
  a_r4_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && (|slot_hit) && !key1_open) |-> host_rdata == 8'h00);
  a_r10_unknown_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !(|slot_hit) && idx_q != IDX_ID && idx_q != IDX_KEY1 &&
     idx_q != IDX_KEY2) |-> host_rdata == 8'h00);
  a_r11_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> ($stable(bank_num) && $stable(disp_start_hi) && $stable(aper_base)));
  a_r1_index_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel) |=> idx_q == $past(host_wdata));
endmodule

// File: tb/xcrtc_regfile_tb.sv
`timescale 1ns/1ps
module xcrtc_regfile_tb;
  localparam logic [7:0] ID = 8'h90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [5:0] bank_num;
  logic [2:0] disp_start_hi;
  logic [9:0] aper_base;

  always #2.5 clk = ~clk;

  xcrtc_regfile #(.CHIP_ID(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bank_num(bank_num),
    .disp_start_hi(disp_start_hi), .aper_base(aper_base)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  int m_idx = 0, m_k1 = 0, m_k2 = 0;
  bit m_k2open = 0;
  int m_mem [int];

  function automatic int mget(int i);
    return m_mem.exists(i) ? m_mem[i] : 0;
  endfunction

  function automatic bit in_grp1(int i);
    return i == 'h31 || i == 'h35 || i == 'h59 || i == 'h5A;
  endfunction

  function automatic int model_read(bit sel);
    bit k1 = (m_k1 == 'h48);
    if (!sel) return m_idx;
    if (m_idx == 'h30) return ID;
    if (m_idx == 'h38) return m_k1;
    if (m_idx == 'h39) return m_k2;
    if (in_grp1(m_idx)) return k1 ? mget(m_idx) : 0;
    if (m_idx == 'h51) return (k1 && m_k2open) ? mget('h51) : 0;
    return 0;
  endfunction

  task automatic model_write(bit sel, int d);
    bit k1 = (m_k1 == 'h48);
    if (!sel) begin m_idx = d; return; end
    if (m_idx == 'h38) m_k1 = d;
    else if (m_idx == 'h39) begin
      m_k2 = d;
      if (d == 'hA5) m_k2open = 1;
      else if (d == 'h5A) m_k2open = 0;
    end else if (in_grp1(m_idx) && k1) m_mem[m_idx] = d;
    else if (m_idx == 'h51 && k1 && m_k2open) m_mem['h51] = d;
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison of the assembled outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 bank_num", bank_num, ((mget('h51) >> 2) & 3) << 4 | (mget('h35) & 'hF));
      check("R7 disp_start_hi", disp_start_hi, (mget('h51) & 1) << 2 | ((mget('h31) >> 4) & 3));
      check("R8 aper_base", aper_base, (mget('h59) & 3) << 8 | mget('h5A));
    end
  end

  task automatic wr(bit sel, int d);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = d[7:0];
    @(posedge clk);
    model_write(sel, d);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(bit sel, string req);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b0;
    #1;
    check(req, host_rdata, model_read(sel));
  endtask

  task automatic put(int i, int d);
    wr(0, i); wr(1, d);
  endtask

  task automatic peek(int i, string req);
    wr(0, i); rd(1, req);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 32'h1234_5679;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(0, "R10 index after reset");
    check("R10 bank after reset", bank_num, 0);
    peek('h38, "R10 key1 after reset");
    peek('h35, "R10 bank reg locked read");
    // R9 id, locked
    peek('h30, "R9 id while locked");
    put('h30, 'h12); peek('h30, "R9 id write ignored");
    // R4 locked write ignored (detection)
    put('h35, 'h0F); peek('h35, "R4 locked bank write");
    check("R4 bank unchanged", bank_num, 0);
    // R2 open
    put('h38, 'h48); peek('h38, "R2 key1 readback");
    put('h35, 'h0F); peek('h35, "R4 bank writable");
    put('h31, 'h30); put('h59, 'h03); put('h5A, 'hC3);
    peek('h5A, "R4 aperture low");
    // R5 only key1 open
    put('h51, 'h0D); peek('h51, "R5 single key read");
    check("R5 high bits still zero", bank_num, 6'h0F);
    // R3 open key2
    put('h39, 'hA5); peek('h39, "R3 key2 readback");
    put('h51, 'h0D); peek('h51, "R5 both keys");
    check("R6 bank assembled", bank_num, 6'h3F);
    check("R7 start assembled", disp_start_hi, 3'b111);
    check("R8 aperture assembled", aper_base, 10'h3C3);
    // R3 other value keeps key2 open
    put('h39, 'h11); put('h51, 'h08); peek('h51, "R3 other value keeps");
    // R2 any other value closes, R11 retention
    put('h38, 'h47);
    peek('h35, "R2 other value closes");
    check("R11 bank retained", bank_num, 6'h2F);
    check("R11 aperture retained", aper_base, 10'h3C3);
    put('h38, 'h48); peek('h35, "R11 value back after reopen");
    put('h39, 'h5A); put('h51, 'h00); peek('h51, "R3 key2 shut");
    // R10 unknown index
    put('h77, 'hAB); peek('h77, "R10 unknown index");
    // R1 index port
    wr(0, 'hE4); rd(0, "R1 index readback");
    // mixed stream
    for (int n = 0; n < 1500; n++) begin
      int pick, val;
      int ilist [10] = '{'h30, 'h31, 'h35, 'h38, 'h39, 'h51, 'h59, 'h5A, 'h77, 'h38};
      int vlist [6]  = '{'h48, 'hA5, 'h5A, 'h00, 'h48, 'hA5};
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      pick = (seed >>> 4) & 15;
      val  = ((seed >>> 12) & 3) == 0 ? vlist[(seed >>> 20) & 3] : (seed >>> 8) & 'hFF;
      if (pick < 10) put(ilist[pick], val);
      else peek(ilist[pick - 6], "R4 R5 stream read");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule